// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming frame is kept, based on its 48-bit destination address and its length. For each request it produces one accept or drop decision. The decision registers in the cycle after the request, and the block raises a one-cycle valid pulse with it. The destination address arrives packed with its first byte on the wire in bits 7:0, its second byte in bits 15:8, and so on up to the sixth byte in bits 47:40.

Software configures the filter through 32-bit register writes at word offsets. Two offsets hold each of the two unicast match addresses. Two more hold the 64-bit group hash table, and one holds a control word with four enables. A frame passes if any enabled source claims it: a unicast match, the broadcast address, or a hit in the hash table. Frames too short to carry both addresses are always dropped.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset all filter registers are zero, `dec_valid` is low, and every frame is dropped until software writes the registers.
- R2: `dec_valid` is high for exactly one cycle, in the cycle after `addr_valid` is sampled high. `dec_accept` is never high while `dec_valid` is low.
- R3: A frame with `frame_len` below 12 is dropped whatever its address. A frame of length exactly 12 is eligible.
- R4: Unicast slot 0 is loaded by a write at offset 0 and a write at offset 1. Offset 0 carries address bytes 0..3, with byte 0 in bits 7:0. Offset 1 carries bytes 4 and 5 in bits 15:0. When control bit 0 is set, a frame whose address equals slot 0 in all 48 bits is accepted, and a difference in any byte gives no match.
- R5: Unicast slot 1 uses offsets 2 (low) and 3 (high), with the same byte layout as slot 0. It is enabled by control bit 1.
- R6: When control bit 3 is set, a frame to the all-ones address is accepted.
- R7: The hash index is the XOR of the eight 6-bit slices `dst_addr[6k+5:6k]`, for k from 0 to 7. Index 0..31 selects that bit of the group low register at offset 4. Index 32..63 selects bit (index-32) of the group high register at offset 5. A set bit gives a group hit.
- R8: While control bit 2 is clear, only addresses with `dst_addr[0]` set can produce a group hit. While bit 2 is set, addresses with bit 0 clear are hashed too.
- R9: The control word is written at offset 7, bits 3:0. A write at offset 6 changes no decision.
- R10: The decision is the OR of all sources. Any one hit accepts the frame; no hit drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 3 | Register word offset |
| wr_data | input | 32 | Register write data |
| addr_valid | input | 1 | Destination address and length are valid this cycle |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_len | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | Decision valid pulse |
| dec_accept | output | 1 | 1 = accept, 0 = drop |

## Verification
Some rules are checked by the assertions on every cycle. These cover the one-cycle timing of the decision pulse and that accept is only given with it. They also cover that short frames are dropped, that an enabled unicast or broadcast match always accepts, and that a non-multicast address cannot pass through the hash table while individual hashing is off. The assertions also check that the control word loads from offset 7. Other behaviours can only be shown by the bench's scenarios. These are the exact byte packing of the unicast registers and the hash fold with its split between the low and high table halves. They also include that offset 6 has no effect and the reset state.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MAC_W      = 48;
  localparam int SLICE_W    = 6;
  localparam int NUM_SLICES = MAC_W / SLICE_W;
  localparam int TBL_BITS   = 1 << SLICE_W;
  localparam int NUM_UCAST  = 2;

  localparam logic [2:0] OFF_GRP_LO = 3'd4;
  localparam logic [2:0] OFF_GRP_HI = 3'd5;
  localparam logic [2:0] OFF_CTRL   = 3'd7;

  // Control word layout (bits 3:0 of the write at OFF_CTRL)
  typedef struct packed {
    logic       bcast_en;    // bit 3
    logic       indiv_hash;  // bit 2
    logic [1:0] ucast_en;    // bit 1: slot 1, bit 0: slot 0
  } rx_ctrl_t;

  // XOR-fold of the address into a table index
  function automatic logic [SLICE_W-1:0] hash_fold(input logic [MAC_W-1:0] a);
    logic [SLICE_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NUM_SLICES; k++) begin
      acc = acc ^ a[k*SLICE_W +: SLICE_W];
    end
    return acc;
  endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [2:0]                     wr_off,
  input  logic [31:0]                    wr_data,
  output logic [NUM_UCAST-1:0][MAC_W-1:0] ucast_addr,
  output logic [TBL_BITS-1:0]            grp_tbl,
  output rx_ctrl_t                       ctrl
);
  localparam int HI_W = MAC_W - 32;

  logic [31:0] grp_lo_q, grp_hi_q;
  rx_ctrl_t    ctrl_q;

  for (genvar s = 0; s < NUM_UCAST; s++) begin : g_slot
    localparam logic [2:0] OFF_LO = 3'(2 * s);
    localparam logic [2:0] OFF_HI = 3'(2 * s + 1);
    logic [31:0]     lo_q;
    logic [HI_W-1:0] hi_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en) begin
        if (wr_off == OFF_LO) lo_q <= wr_data;
        if (wr_off == OFF_HI) hi_q <= wr_data[HI_W-1:0];
      end
    end
    assign ucast_addr[s] = {hi_q, lo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_lo_q <= '0;
      grp_hi_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      case (wr_off)
        OFF_GRP_LO: grp_lo_q <= wr_data;
        OFF_GRP_HI: grp_hi_q <= wr_data;
        OFF_CTRL:   ctrl_q   <= rx_ctrl_t'(wr_data[3:0]);
        default: ;
      endcase
    end
  end

  assign grp_tbl = {grp_hi_q, grp_lo_q};
  assign ctrl    = ctrl_q;

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_CTRL) |=> (ctrl == rx_ctrl_t'($past(wr_data[3:0])))); // R9
endmodule

// File: rtl/rxf_hash.sv
module rxf_hash
  import rxf_pkg::*;
(
  input  logic [MAC_W-1:0]    dst,
  input  logic [TBL_BITS-1:0] tbl,
  input  logic                indiv_en,
  output logic [SLICE_W-1:0]  idx,
  output logic                grp_hit
);
  logic eligible;
  assign idx      = hash_fold(dst);
  assign eligible = indiv_en | dst[0];
  assign grp_hit  = eligible & tbl[idx];
endmodule

// File: rtl/rxf_ucast_cmp.sv
module rxf_ucast_cmp
  import rxf_pkg::*;
(
  input  logic [MAC_W-1:0] dst,
  input  logic [MAC_W-1:0] ref_addr,
  input  logic             en,
  output logic             hit
);
  assign hit = en && (dst == ref_addr);
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 len_ok,
  input  logic [NUM_UCAST-1:0] ucast_hit,
  input  logic                 bcast_hit,
  input  logic                 grp_hit,
  output logic                 valid,
  output logic                 accept
);
  logic any_hit;
  assign any_hit = (|ucast_hit) | bcast_hit | grp_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      accept <= 1'b0;
    end else begin
      valid  <= req;
      accept <= req & len_ok & any_hit;
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_off,
  input  logic [31:0]      wr_data,
  input  logic             addr_valid,
  input  logic [MAC_W-1:0] dst_addr,
  input  logic [LEN_W-1:0] frame_len,
  output logic             dec_valid,
  output logic             dec_accept
);
  localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

  logic [NUM_UCAST-1:0][MAC_W-1:0] ucast_addr;
  logic [TBL_BITS-1:0]             grp_tbl;
  rx_ctrl_t                        ctrl;
  logic [NUM_UCAST-1:0]            ucast_hit;
  logic                            bcast_hit;
  logic                            grp_hit;
  logic [SLICE_W-1:0]              hash_idx;
  logic                            len_ok;

  rxf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .ucast_addr(ucast_addr), .grp_tbl(grp_tbl), .ctrl(ctrl)
  );

  for (genvar s = 0; s < NUM_UCAST; s++) begin : g_cmp
    rxf_ucast_cmp u_cmp (
      .dst(dst_addr), .ref_addr(ucast_addr[s]), .en(ctrl.ucast_en[s]), .hit(ucast_hit[s])
    );
  end

  rxf_hash u_hash (
    .dst(dst_addr), .tbl(grp_tbl), .indiv_en(ctrl.indiv_hash),
    .idx(hash_idx), .grp_hit(grp_hit)
  );

  assign bcast_hit = ctrl.bcast_en && (&dst_addr);
  assign len_ok    = (frame_len >= MIN_LEN_V);

  rxf_decide u_dec (
    .clk(clk), .rst_n(rst_n), .req(addr_valid), .len_ok(len_ok),
    .ucast_hit(ucast_hit), .bcast_hit(bcast_hit), .grp_hit(grp_hit),
    .valid(dec_valid), .accept(dec_accept)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> dec_valid); // R2
  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(addr_valid)); // R2
  AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid); // R2
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && frame_len < MIN_LEN_V) |=> !dec_accept); // R3
  AST_UCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && len_ok && (|ucast_hit)) |=> dec_accept); // R4
  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && len_ok && ctrl.bcast_en && (&dst_addr)) |=> dec_accept); // R6
  AST_GROUP_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !ctrl.indiv_hash && !dst_addr[0] && !(|ucast_hit)) |=> !dec_accept); // R8
endmodule

// File: tb/rx_dest_filter_test.sv
`timescale 1ns/1ps
module rx_dest_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_off = '0;
  logic [31:0] wr_data = '0;
  logic        addr_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic [15:0] frame_len = '0;
  logic        dec_valid, dec_accept;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  rx_dest_filter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .addr_valid(addr_valid), .dst_addr(dst_addr), .frame_len(frame_len),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // Addresses: byte 0 (first on wire) sits in bits 7:0
  localparam logic [47:0] UA0   = 48'h5544_3322_1102;
  localparam logic [47:0] UA1   = 48'h9988_7766_5504;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC1   = 48'h0100_005E_0001;
  localparam logic [47:0] MC2   = MC1 ^ 48'h100;   // one bit off: other index
  localparam logic [47:0] IND2  = MC1 ^ 48'h41;    // bit0 cleared, same index

  typedef struct packed {
    logic [47:0] a;
    logic [15:0] len;
    logic        exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{UA0,   16'd64, 1'b1},                       // R4 R10
    '{UA1,   16'd64, 1'b1},                       // R5
    '{BCAST, 16'd64, 1'b1},                       // R6
    '{MC1,   16'd64, 1'b1},                       // R7
    '{MC2,   16'd64, 1'b0},                       // R7
    '{UA0,   16'd11, 1'b0},                       // R3
    '{UA0,   16'd12, 1'b1},                       // R3
    '{UA0 ^ (48'h1 << 40), 16'd64, 1'b0},         // R4
    '{IND2,  16'd64, 1'b0},                       // R8
    '{BCAST, 16'd11, 1'b0}                        // R3
  };
  localparam string VTAG [NV] = '{"R4", "R5", "R6", "R7", "R7", "R3", "R3", "R4", "R8", "R3"};

  // Reference index: walk every address bit, fold by position mod 6
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [5:0] r;
    r = '0;
    for (int b = 0; b < 48; b++) r[b % 6] = r[b % 6] ^ a[b];
    return r;
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_group_bit(input int idx);
    write_reg(3'd4, (idx < 32) ? (32'h1 << idx) : 32'h0);
    write_reg(3'd5, (idx >= 32) ? (32'h1 << (idx - 32)) : 32'h0);
  endtask

  task automatic send(input logic [47:0] a, input logic [15:0] len, input logic exp, input string req);
    @(negedge clk);
    addr_valid = 1'b1; dst_addr = a; frame_len = len;
    @(negedge clk);
    addr_valid = 1'b0;
    check(dec_valid, 1'b1, "R2", "valid pulse");
    check(dec_accept, exp, req, "decision");
    @(negedge clk);
    check(dec_valid, 1'b0, "R2", "valid drops after one cycle");
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dec_valid, 1'b0, "R1", "valid after reset");
    send(BCAST, 16'd64, 1'b0, "R1");
    send(48'h0, 16'd64, 1'b0, "R1");

    // Configuration for the vector table
    write_reg(3'd0, 32'h3322_1102);
    write_reg(3'd1, 32'h0000_5544);
    write_reg(3'd2, 32'h7766_5504);
    write_reg(3'd3, 32'h0000_9988);
    set_group_bit(int'(ref_index(MC1)));
    write_reg(3'd7, 32'h0000_000B);   // ucast0, ucast1, bcast; no indiv hash

    for (int i = 0; i < NV; i++) send(VECS[i].a, VECS[i].len, VECS[i].exp, VTAG[i]);

    // R8: individual hashing lets the even address through
    write_reg(3'd7, 32'h0000_000F);
    send(IND2, 16'd64, 1'b1, "R8");

    // R4: slot 0 disabled
    write_reg(3'd7, 32'h0000_000A);
    send(UA0, 16'd64, 1'b0, "R4");
    send(UA1, 16'd64, 1'b1, "R5");

    // R9: offset 6 has no effect
    write_reg(3'd7, 32'h0);
    write_reg(3'd6, 32'hFFFF_FFFF);
    send(BCAST, 16'd64, 1'b0, "R9");
    send(UA0, 16'd64, 1'b0, "R9");

    // R7: table halves and boundaries, individual hashing on
    write_reg(3'd7, 32'h0000_0004);
    foreach (VTAG[k]) begin end
    for (int j = 0; j < 4; j++) begin
      int idx;
      idx = (j == 0) ? 0 : (j == 1) ? 31 : (j == 2) ? 32 : 63;
      set_group_bit(idx);
      send(48'(idx), 16'd64, 1'b1, "R7");
      send(48'(idx ^ 1), 16'd64, 1'b0, "R7");
    end

    // R10: several sources at once still accept; none drops
    write_reg(3'd7, 32'h0000_000F);
    set_group_bit(int'(ref_index(UA0)));
    send(UA0, 16'd64, 1'b1, "R10");
    send(48'h0000_0000_0A02, 16'd64, (ref_index(48'h0000_0000_0A02) == ref_index(UA0)), "R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule